// File: doc/BRIEF.md
# Windowed Watchdog with Device Reset

This block supervises a host that must clear it periodically. Each supervision period is measured in prescaled ticks and splits into two halves. In the first half the window is closed, and a clear there is a fault. In the second half the window is open, and a clear there is valid and starts a fresh period. If the whole period passes with no clear, that is also a fault. Every fault drives a reset pulse of fixed length that is meant to reset the whole device.

After device reset the block sits idle in a request state. It leaves that state when a mode-entry pulse arrives. The first clear after that pulse may come at any time, with no window check. Only then does windowed supervision start. A two-bit configuration input selects one of three settings: a built-in default period, a programmed period, or full disable. A new configuration is taken up only when a period starts. The clear strobe is a single-cycle pulse that logic elsewhere decodes from a control register write.

Top module: `window_watchdog`

## Requirements
- R1: After reset, `wdt_rst_o` and `win_open_o` are 0 and the block is idle: clears are ignored and no timeout runs until `enter_normal_i` is pulsed.
- R2: In windowed operation, a clear sampled while fewer than floor(period/2) ticks have elapsed causes `wdt_rst_o` to go high from the next cycle.
- R3: With no clear, `wdt_rst_o` goes high exactly period×PRESCALE clock cycles after the clock edge that started the period. This applies to windowed operation and to the first-clear state.
- R4: A clear sampled when at least floor(period/2) ticks have elapsed is accepted, produces no reset, and starts a new period with a closed window. A clear on the same edge as the final tick is accepted.
- R5: After an `enter_normal_i` pulse, a clear at any time, including the very next cycle, is accepted without a window check and starts windowed operation.
- R6: `cfg_mode_i` is decoded as follows: 2'b00 disables; 2'b01 selects DEFAULT_PERIOD ticks; 2'b10 or 2'b11 selects `cfg_period_i` ticks. A programmed value below 2 is raised to 2.
- R7: While a period runs with the disable setting, `wdt_rst_o` never goes high. A clear in that state restarts the period and takes up the configuration again.
- R8: `wdt_rst_o` stays high for exactly RST_CYCLES cycles. On the edge that ends the pulse, the block enters the first-clear state with a new period.
- R9: `win_open_o` is high exactly while windowed operation is in its open half, and is never high together with `wdt_rst_o`.
- R10: A change of `cfg_mode_i` or `cfg_period_i` during a period has no effect until the next period start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Single-cycle clear strobe from the host |
| enter_normal_i | input | 1 | Pulse marking entry into normal operation |
| cfg_mode_i | input | 2 | Period source: 00 disable, 01 default, 1x programmed |
| cfg_period_i | input | PERIOD_W | Programmed period in prescaled ticks |
| wdt_rst_o | output | 1 | Device reset pulse |
| win_open_o | output | 1 | High while the open window is active |

## Verification
The hardest case to reach is a clear that lands on the exact edge of a window boundary. This happens on the last closed cycle, on the first open cycle, and on the edge where the final tick would fire the timeout. These edges lie many prescaled ticks after the period start. The stimulus therefore places every windowed clear at a cycle offset counted from the edge that accepted the unwindowed first clear. Each offset comes from a table, and those offsets straddle each boundary for several period settings. A separate directed case changes the period in the middle of a period. It then places one clear that is legal only under the old setting and a second clear that is legal only under the new one.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIRST = 2'd1,
        ST_WIN   = 2'd2,
        ST_RST   = 2'd3
    } wdt_state_e;

    localparam logic [1:0] CFG_OFF = 2'b00;
    localparam logic [1:0] CFG_DEF = 2'b01;

    localparam int unsigned MIN_PERIOD = 2;

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int unsigned PRESCALE = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic restart_i,
    output logic tick_o
);

    generate
        if (PRESCALE <= 1) begin : g_direct
            assign tick_o = 1'b1;
        end else begin : g_count
            localparam int unsigned PW = $clog2(PRESCALE);
            localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

            typedef struct packed {
                logic [PW-1:0] pre;
            } pre_state_t;

            pre_state_t s_d, s_q;

            assign tick_o = (s_q.pre == LAST);

            always_comb begin
                s_d = s_q;
                if (restart_i || tick_o) begin
                    s_d.pre = '0;
                end else begin
                    s_d.pre = s_q.pre + 1'b1;
                end
            end

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    s_q <= '0;
                end else begin
                    s_q <= s_d;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/wdt_period_sel.sv
module wdt_period_sel
    import wdt_pkg::*;
#(
    parameter int unsigned PERIOD_W       = 8,
    parameter int unsigned DEFAULT_PERIOD = 150
) (
    input  logic [1:0]          mode_i,
    input  logic [PERIOD_W-1:0] prog_i,
    output logic [PERIOD_W-1:0] period_o,
    output logic                off_o
);

    localparam logic [PERIOD_W-1:0] DEF_TICKS = PERIOD_W'(DEFAULT_PERIOD);
    localparam logic [PERIOD_W-1:0] MIN_TICKS = PERIOD_W'(MIN_PERIOD);

    logic [PERIOD_W-1:0] prog_clamped;

    always_comb begin
        prog_clamped = (prog_i < MIN_TICKS) ? MIN_TICKS : prog_i;
        off_o        = (mode_i == CFG_OFF);
        if (mode_i[1]) begin
            period_o = prog_clamped;
        end else if (mode_i == CFG_DEF) begin
            period_o = DEF_TICKS;
        end else begin
            period_o = MIN_TICKS;
        end
    end

endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int unsigned PERIOD_W   = 8,
    parameter int unsigned RST_CYCLES = 4
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                tick_i,
    input  logic                clear_i,
    input  logic                enter_i,
    input  logic [PERIOD_W-1:0] sel_period_i,
    input  logic                sel_off_i,
    output logic                restart_o,
    output logic                wdt_rst_o,
    output logic                win_open_o,
    output logic                armed_o,
    output logic                off_o
);

    localparam int unsigned RW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
    localparam logic [RW-1:0] RST_LAST = RW'(RST_CYCLES - 1);

    typedef struct packed {
        wdt_state_e          state;
        logic [PERIOD_W-1:0] cnt;
        logic [PERIOD_W-1:0] period;
        logic [PERIOD_W-1:0] half;
        logic                off;
        logic [RW-1:0]       rcnt;
    } core_state_t;

    core_state_t s_d, s_q;

    logic running;
    logic in_open;
    logic tick_end;
    logic restart;

    always_comb begin
        running  = ((s_q.state == ST_FIRST) || (s_q.state == ST_WIN)) && !s_q.off;
        in_open  = (s_q.cnt >= s_q.half);
        tick_end = running && tick_i && (s_q.cnt == (s_q.period - 1'b1));
        restart  = 1'b0;
        s_d      = s_q;

        if (running && tick_i) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end

        unique case (s_q.state)
            ST_IDLE: begin
                if (enter_i) begin
                    s_d.state = ST_FIRST;
                    restart   = 1'b1;
                end
            end
            ST_FIRST: begin
                if (enter_i) begin
                    restart = 1'b1;
                end else if (clear_i) begin
                    s_d.state = ST_WIN;
                    restart   = 1'b1;
                end else if (tick_end) begin
                    s_d.state = ST_RST;
                end
            end
            ST_WIN: begin
                if (enter_i) begin
                    s_d.state = ST_FIRST;
                    restart   = 1'b1;
                end else if (clear_i) begin
                    if (s_q.off || in_open) begin
                        restart = 1'b1;
                    end else begin
                        s_d.state = ST_RST;
                    end
                end else if (tick_end) begin
                    s_d.state = ST_RST;
                end
            end
            ST_RST: begin
                if (s_q.rcnt == RST_LAST) begin
                    s_d.state = ST_FIRST;
                    s_d.rcnt  = '0;
                    restart   = 1'b1;
                end else begin
                    s_d.rcnt = s_q.rcnt + 1'b1;
                end
            end
            default: begin
                s_d.state = ST_IDLE;
            end
        endcase

        if (s_d.state == ST_RST && s_q.state != ST_RST) begin
            s_d.rcnt = '0;
            s_d.cnt  = '0;
        end

        if (restart) begin
            s_d.cnt    = '0;
            s_d.period = sel_period_i;
            s_d.half   = sel_period_i >> 1;
            s_d.off    = sel_off_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{state: ST_IDLE, cnt: '0, period: '0, half: '0, off: 1'b0, rcnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign restart_o  = restart;
    assign wdt_rst_o  = (s_q.state == ST_RST);
    assign armed_o    = (s_q.state == ST_WIN) && !s_q.off;
    assign win_open_o = armed_o && in_open;
    assign off_o      = s_q.off;

endmodule

// File: rtl/window_watchdog.sv
module window_watchdog #(
    parameter int unsigned PRESCALE       = 4,
    parameter int unsigned PERIOD_W       = 8,
    parameter int unsigned DEFAULT_PERIOD = 150,
    parameter int unsigned RST_CYCLES     = 4
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                clear_i,
    input  logic                enter_normal_i,
    input  logic [1:0]          cfg_mode_i,
    input  logic [PERIOD_W-1:0] cfg_period_i,
    output logic                wdt_rst_o,
    output logic                win_open_o
);

    logic                tick;
    logic                restart;
    logic [PERIOD_W-1:0] sel_period;
    logic                sel_off;
    logic                armed;
    logic                cur_off;

    wdt_prescaler #(
        .PRESCALE (PRESCALE)
    ) u_prescaler (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (restart),
        .tick_o    (tick)
    );

    wdt_period_sel #(
        .PERIOD_W       (PERIOD_W),
        .DEFAULT_PERIOD (DEFAULT_PERIOD)
    ) u_period_sel (
        .mode_i   (cfg_mode_i),
        .prog_i   (cfg_period_i),
        .period_o (sel_period),
        .off_o    (sel_off)
    );

    wdt_core #(
        .PERIOD_W   (PERIOD_W),
        .RST_CYCLES (RST_CYCLES)
    ) u_core (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .tick_i       (tick),
        .clear_i      (clear_i),
        .enter_i      (enter_normal_i),
        .sel_period_i (sel_period),
        .sel_off_i    (sel_off),
        .restart_o    (restart),
        .wdt_rst_o    (wdt_rst_o),
        .win_open_o   (win_open_o),
        .armed_o      (armed),
        .off_o        (cur_off)
    );

endmodule

// File: rtl/window_watchdog_chk.sv
module window_watchdog_chk #(
    parameter int unsigned RST_CYCLES = 4
) (
    input logic clk_i,
    input logic rst_ni,
    input logic clear_i,
    input logic enter_normal_i,
    input logic wdt_rst_o,
    input logic win_open_o,
    input logic armed,
    input logic cur_off
);

    localparam int unsigned HW = $clog2(RST_CYCLES + 1) + 1;

    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hi_cnt <= '0;
        end else if (wdt_rst_o) begin
            hi_cnt <= hi_cnt + 1'b1;
        end else begin
            hi_cnt <= '0;
        end
    end

    p_closed_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed && !win_open_o && clear_i && !enter_normal_i) |=> wdt_rst_o);

    p_open_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed && win_open_o && clear_i && !enter_normal_i) |=> (!wdt_rst_o && !win_open_o));

    p_disabled_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cur_off && !wdt_rst_o) |=> !wdt_rst_o);

    p_pulse_max_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wdt_rst_o |-> (hi_cnt < HW'(RST_CYCLES)));

    p_pulse_len_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(wdt_rst_o) |-> (hi_cnt == HW'(RST_CYCLES)));

    p_win_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        win_open_o |-> !wdt_rst_o);

endmodule

bind window_watchdog window_watchdog_chk #(
    .RST_CYCLES (RST_CYCLES)
) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .clear_i        (clear_i),
    .enter_normal_i (enter_normal_i),
    .wdt_rst_o      (wdt_rst_o),
    .win_open_o     (win_open_o),
    .armed          (armed),
    .cur_off        (cur_off)
);

// File: tb/test_window_watchdog.sv
`timescale 1ns/1ps
module test_window_watchdog;

    localparam int unsigned P   = 4;
    localparam int unsigned PW  = 8;
    localparam int unsigned DEF = 150;
    localparam int unsigned RC  = 4;

    localparam logic [1:0] M_OFF  = 2'b00;
    localparam logic [1:0] M_DEF  = 2'b01;
    localparam logic [1:0] M_PROG = 2'b10;

    typedef struct packed {
        logic [1:0]  mode;
        logic [7:0]  period;
        logic [15:0] k;
        logic        exp_rst;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{M_PROG, 8'd10, 16'd1,   1'b1},
        '{M_PROG, 8'd10, 16'd20,  1'b1},
        '{M_PROG, 8'd10, 16'd21,  1'b0},
        '{M_PROG, 8'd10, 16'd40,  1'b0},
        '{M_PROG, 8'd7,  16'd12,  1'b1},
        '{M_PROG, 8'd7,  16'd13,  1'b0},
        '{M_PROG, 8'd7,  16'd28,  1'b0},
        '{M_OFF,  8'd10, 16'd1,   1'b0},
        '{M_OFF,  8'd10, 16'd5,   1'b0},
        '{M_DEF,  8'd3,  16'd300, 1'b1},
        '{M_DEF,  8'd3,  16'd301, 1'b0},
        '{M_PROG, 8'd1,  16'd4,   1'b1},
        '{M_PROG, 8'd1,  16'd5,   1'b0}
    };

    logic          clk_i = 1'b0;
    logic          rst_ni = 1'b0;
    logic          clear_i = 1'b0;
    logic          enter_normal_i = 1'b0;
    logic [1:0]    cfg_mode_i = M_PROG;
    logic [PW-1:0] cfg_period_i = 8'd10;
    logic          wdt_rst_o;
    logic          win_open_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk_i = ~clk_i;

    window_watchdog #(
        .PRESCALE (P), .PERIOD_W (PW), .DEFAULT_PERIOD (DEF), .RST_CYCLES (RC)
    ) i_window_watchdog (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .clear_i        (clear_i),
        .enter_normal_i (enter_normal_i),
        .cfg_mode_i     (cfg_mode_i),
        .cfg_period_i   (cfg_period_i),
        .wdt_rst_o      (wdt_rst_o),
        .win_open_o     (win_open_o)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk_i);
        rst_ni = 1'b0;
        clear_i = 1'b0;
        enter_normal_i = 1'b0;
        repeat (2) @(negedge clk_i);
        rst_ni = 1'b1;
    endtask

    task automatic pulse_enter();
        enter_normal_i = 1'b1;
        @(negedge clk_i);
        enter_normal_i = 1'b0;
    endtask

    task automatic clear_at(input int k);
        repeat (k - 1) @(negedge clk_i);
        clear_i = 1'b1;
        @(negedge clk_i);
        clear_i = 1'b0;
    endtask

    initial begin
        do_reset();
        check("R1 reset rst", wdt_rst_o, 1'b0);
        check("R1 reset win", win_open_o, 1'b0);
        clear_at(1);
        repeat (1000) @(negedge clk_i);
        check("R1 idle ignores clear", wdt_rst_o, 1'b0);

        for (int i = 0; i < NV; i++) begin
            do_reset();
            cfg_mode_i   = VECS[i].mode;
            cfg_period_i = VECS[i].period;
            pulse_enter();
            clear_at(1);
            check("R5 first clear", wdt_rst_o, 1'b0);
            clear_at(int'(VECS[i].k));
            if (VECS[i].exp_rst)
                check("R2 closed clear vector", wdt_rst_o, 1'b1);
            else
                check("R4 R6 R7 accepted clear vector", wdt_rst_o, 1'b0);
        end

        do_reset();
        cfg_mode_i = M_PROG;
        cfg_period_i = 8'd10;
        pulse_enter();
        clear_at(1);
        repeat (5 * P - 1) @(negedge clk_i);
        check("R9 window still closed", win_open_o, 1'b0);
        @(negedge clk_i);
        check("R9 window open", win_open_o, 1'b1);
        repeat (5 * P - 1) @(negedge clk_i);
        check("R3 no reset before end", wdt_rst_o, 1'b0);
        @(negedge clk_i);
        check("R3 timeout reset", wdt_rst_o, 1'b1);
        check("R9 win low in reset", win_open_o, 1'b0);
        repeat (RC - 1) @(negedge clk_i);
        check("R8 pulse still high", wdt_rst_o, 1'b1);
        @(negedge clk_i);
        check("R8 pulse ended", wdt_rst_o, 1'b0);
        repeat (10 * P - 1) @(negedge clk_i);
        check("R8 first-clear state no early reset", wdt_rst_o, 1'b0);
        @(negedge clk_i);
        check("R3 R8 first-clear state timeout", wdt_rst_o, 1'b1);

        do_reset();
        cfg_mode_i = M_OFF;
        pulse_enter();
        clear_at(1);
        repeat (3000) @(negedge clk_i);
        check("R7 disabled never resets", wdt_rst_o, 1'b0);

        do_reset();
        cfg_mode_i = M_PROG;
        cfg_period_i = 8'd10;
        pulse_enter();
        clear_at(1);
        cfg_period_i = 8'd20;
        clear_at(40);
        check("R10 old period kept", wdt_rst_o, 1'b0);
        clear_at(41);
        check("R10 new period taken", wdt_rst_o, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule